// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the slave side of a microprocessor bus. It lets a host reach a small bank of 16-bit control registers and a 2048-word by 16-bit shared RAM. The RAM itself sits outside the block. The block drives a single RAM port and watches the word that an internal engine is using in the current cycle. Five strap inputs are sampled once after reset and fix the bus convention for the rest of the run:

- one of two strobe styles;
- the polarity of the data strobe;
- an 8-bit or 16-bit data width;
- the byte order within a word;
- whether the address arrives multiplexed on the data bus.

The bus strobes are asynchronous to the block clock, so they are synchronized before use. A read is served when the strobe is seen to begin. A write takes effect when the strobe is seen to end, using the last address and data held while the strobe was active. When a host RAM access targets the word that the internal engine holds, the engine wins. The host access is parked and an active-low busy output is raised. The parked access completes on the first cycle the engine lets go of that word.

Top module: `hbi_host_if`

## Requirements
- R1: After reset, busy_n is 1, host_d_oe is 0, ram_req is 0 and host_d_out is 0x0000.
- R2: Register word 0 always reads 0x0010, and writes to it change nothing.
- R3: The register word number is address bits 6..1. Register word i, for i from 1 to 7, keeps only its low 2*i bits: bits above those read back 0 and ignore writes. Register words 8 and above read 0.
- R4: A register access happens only while pcs_n is 0 and pcs is 1. Any other combination leaves the registers unchanged.
- R5: A RAM access happens only while both bits of mcs_n are 0. The RAM word address is bus address bits 11..1. If either select is high, the RAM is not touched.
- R6: With strap_ds_mode = 0, rd_n low is a read and wr_n low is a write.
- R7: With strap_ds_mode = 1, rd_n is a data strobe and wr_n gives the direction (1 means read, 0 means write). The strobe is active low when strap_ds_pol = 0 and active high when strap_ds_pol = 1.
- R8: With strap_wide = 1, the low lane host_d[7:0] always transfers. The high lane host_d[15:8] transfers only while bhe_n is 0, so ram_be bit 1 maps to the high byte. On a read with bhe_n = 1, host_d_out[15:8] is 0.
- R9: With strap_wide = 0, only host_d[7:0] carries data. The byte chosen is the high byte when address bit 0 XOR strap_hi_first is 1, and the low byte otherwise. A write sets exactly one ram_be bit. A read returns 0 on host_d_out[15:8].
- R10: With strap_mux_addr = 1, each address half follows the data bus while its enable (ale_lo or ale_hi) is high, and holds that value after the enable falls. host_a is ignored in this mode.
- R11: While a parked host RAM access targets eng_addr and eng_act is 1, busy_n is 0 and no ram_req is issued. The access completes once the engine releases that word. An engine on a different word causes no busy.
- R12: Strap changes after the first clock following reset have no effect.
- R13: A write uses the address and data present at the end of the strobe, not the values present when the strobe began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ds_mode | input | 1 | 0: separate read/write strobes; 1: data strobe plus direction |
| strap_ds_pol | input | 1 | Data strobe polarity (1 = active high) |
| strap_wide | input | 1 | 1: 16-bit bus; 0: 8-bit bus |
| strap_hi_first | input | 1 | Byte order select for the 8-bit bus |
| strap_mux_addr | input | 1 | 1: address multiplexed on the data bus |
| host_a | input | 16 | Host address when not multiplexed |
| host_d_in | input | 16 | Host data bus, inbound |
| host_d_out | output | 16 | Host data bus, outbound |
| host_d_oe | output | 1 | Output enable for host_d_out |
| ale_lo | input | 1 | Low address half latch enable |
| ale_hi | input | 1 | High address half latch enable |
| rd_n | input | 1 | Read strobe or data strobe |
| wr_n | input | 1 | Write strobe or direction |
| bhe_n | input | 1 | High byte lane enable, active low |
| pcs_n | input | 1 | Register select, active low |
| pcs | input | 1 | Register select, active high |
| mcs_n | input | 2 | RAM selects, both active low |
| busy_n | output | 1 | Collision busy, active low |
| ram_req | output | 1 | RAM access strobe for this cycle |
| ram_we | output | 1 | RAM write when 1 |
| ram_addr | output | 11 | RAM word address |
| ram_wdata | output | 16 | RAM write word |
| ram_be | output | 2 | RAM byte enables |
| ram_rdata | input | 16 | RAM read word, combinational from ram_addr |
| eng_act | input | 1 | Internal engine accesses eng_addr this cycle |
| eng_addr | input | 11 | Word held by the internal engine |

## Verification
The assertions assume the host behaves as follows:
- it starts no new strobe while busy_n is low;
- it keeps address, selects and data stable for at least three clocks after a strobe is released, which covers the synchronizer delay;
- it keeps strobes idle until the block has settled after reset.

The stimulus tasks enforce these rules. They hold every strobe for several clocks, keep the data bus driven through the hold window, and wait for busy_n to rise before they return. Only the collision scenarios return early, and those start no further access until the engine has released the word. A write task first places a wrong data value and replaces it mid-strobe, so a write that captured its data early shows up as a mismatch.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef struct packed {
    logic ds_mode;
    logic ds_pol_hi;
    logic wide;
    logic hi_first;
    logic mux_addr;
  } hbi_cfg_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_mux,
  input  logic          ale_lo,
  input  logic          ale_hi,
  input  logic [AW-1:0] bus_d,
  input  logic [AW-1:0] pin_a,
  output logic [AW-1:0] addr_o
);
  localparam int H = AW / 2;

  logic [H-1:0] lo_q, lo_d;
  logic [AW-H-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (ale_lo) lo_d = bus_d[H-1:0];
    if (ale_hi) hi_d = bus_d[AW-1:H];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_comb begin
    if (en_mux) begin
      addr_o[H-1:0]  = ale_lo ? bus_d[H-1:0]  : lo_q;
      addr_o[AW-1:H] = ale_hi ? bus_d[AW-1:H] : hi_q;
    end else begin
      addr_o = pin_a;
    end
  end

  // R10: once the enable is low, the held half no longer follows the bus
  a_r10_low_half_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mux && $past(en_mux) && !ale_lo && $past(!ale_lo)) |-> $stable(addr_o[H-1:0]));
  a_r10_high_half_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mux && $past(en_mux) && !ale_hi && $past(!ale_hi)) |-> $stable(addr_o[AW-1:H]));
endmodule

// File: rtl/hbi_lanes.sv
module hbi_lanes
  import hbi_pkg::*;
#(
  parameter int BW = 8
) (
  input  hbi_cfg_t        cfg,
  input  logic            a0,
  input  logic            bhe_n,
  input  logic [2*BW-1:0] din,
  input  logic [2*BW-1:0] word_in,
  output logic [2*BW-1:0] wr_word,
  output logic [1:0]      wr_be,
  output logic [2*BW-1:0] rd_bus
);
  logic pick_hi;

  assign pick_hi = a0 ^ cfg.hi_first;

  always_comb begin
    if (cfg.wide) begin
      wr_word = din;
      wr_be   = {~bhe_n, 1'b1};
      rd_bus  = {(bhe_n ? {BW{1'b0}} : word_in[2*BW-1:BW]), word_in[BW-1:0]};
    end else begin
      wr_word = {din[BW-1:0], din[BW-1:0]};
      wr_be   = pick_hi ? 2'b10 : 2'b01;
      rd_bus  = {{BW{1'b0}}, (pick_hi ? word_in[2*BW-1:BW] : word_in[BW-1:0])};
    end
  end
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs #(
  parameter int              DW      = 16,
  parameter int              NREG    = 8,
  parameter int              IDXW    = 6,
  parameter logic [DW-1:0]   VERSION = 16'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [DW-1:0]    wr_word,
  input  logic [DW/8-1:0]  wr_be,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [DW-1:0]    rd_word
);
  localparam int NBE  = DW / 8;
  localparam int SELW = $clog2(NREG);

  function automatic logic [DW-1:0] mask_of(input int i);
    if (2 * i >= DW) return '1;
    return (DW'(1) << (2 * i)) - DW'(1);
  endfunction

  logic [NREG-1:0][DW-1:0] bank;

  assign bank[0] = VERSION;

  for (genvar gi = 1; gi < NREG; gi++) begin : g_reg
    localparam logic [DW-1:0] MASK = mask_of(gi);
    logic [DW-1:0] q, d;

    always_comb begin
      d = q;
      if (wr_en && (wr_idx == IDXW'(gi))) begin
        for (int b = 0; b < NBE; b++) begin
          if (wr_be[b]) d[b*8 +: 8] = wr_word[b*8 +: 8];
        end
      end
      d = d & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign bank[gi] = q;

    // R3: bits outside the implemented field stay clear
    a_r3_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~MASK) == '0);
  end

  assign rd_word = (int'(rd_idx) < NREG) ? bank[rd_idx[SELW-1:0]] : '0;
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if
  import hbi_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 16,
  parameter int            RAM_AW   = 11,
  parameter int            NREG     = 8,
  parameter int            REG_IDXW = 6,
  parameter logic [DW-1:0] VERSION  = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_ds_mode,
  input  logic              strap_ds_pol,
  input  logic              strap_wide,
  input  logic              strap_hi_first,
  input  logic              strap_mux_addr,
  input  logic [AW-1:0]     host_a,
  input  logic [DW-1:0]     host_d_in,
  output logic [DW-1:0]     host_d_out,
  output logic              host_d_oe,
  input  logic              ale_lo,
  input  logic              ale_hi,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bhe_n,
  input  logic              pcs_n,
  input  logic              pcs,
  input  logic [1:0]        mcs_n,
  output logic              busy_n,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic [1:0]        ram_be,
  input  logic [DW-1:0]     ram_rdata,
  input  logic              eng_act,
  input  logic [RAM_AW-1:0] eng_addr
);
  localparam int BW = DW / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sq;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i = rst_sq[1];

  // strap capture and warm-up
  hbi_cfg_t   strap_cfg, cfg_q, cfg_d;
  logic [1:0] cnt_q, cnt_d;
  logic       live;

  assign strap_cfg = {strap_ds_mode, strap_ds_pol, strap_wide, strap_hi_first, strap_mux_addr};

  always_comb begin
    cnt_d = cnt_q;
    cfg_d = cfg_q;
    if (cnt_q != 2'd3) cnt_d = cnt_q + 2'd1;
    if (cnt_q == 2'd0) cfg_d = strap_cfg;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cnt_q <= 2'd0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cfg_q <= cfg_d;
    end
  end

  assign live = (cnt_q == 2'd3);

  // strobe synchronizer and decode
  logic [1:0] strb_s;
  logic       ds_on, rd_act, wr_act, rd_q, wr_q, rd_start, wr_end;

  hbi_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_i), .d({wr_n, rd_n}), .q(strb_s)
  );

  always_comb begin
    ds_on = cfg_q.ds_pol_hi ? strb_s[0] : ~strb_s[0];
    if (cfg_q.ds_mode) begin
      rd_act = live & ds_on & strb_s[1];
      wr_act = live & ds_on & ~strb_s[1];
    end else begin
      rd_act = live & ~strb_s[0];
      wr_act = live & ~strb_s[1] & strb_s[0];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_start = rd_act & ~rd_q;
  assign wr_end   = ~wr_act & wr_q;

  // address path
  logic [AW-1:0] eff_addr;
  logic          sel_reg_raw, sel_ram_raw;

  hbi_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst_n(rst_i), .en_mux(cfg_q.mux_addr), .ale_lo(ale_lo), .ale_hi(ale_hi),
    .bus_d(host_d_in), .pin_a(host_a), .addr_o(eff_addr)
  );

  assign sel_reg_raw = ~pcs_n & pcs;
  assign sel_ram_raw = (mcs_n == 2'b00);

  // write-side capture while the write strobe is active
  logic [AW-1:0] cap_addr_q, cap_addr_d;
  logic [DW-1:0] cap_din_q, cap_din_d;
  logic          cap_bhe_q, cap_bhe_d, cap_reg_q, cap_reg_d, cap_ram_q, cap_ram_d;

  always_comb begin
    cap_addr_d = cap_addr_q;
    cap_din_d  = cap_din_q;
    cap_bhe_d  = cap_bhe_q;
    cap_reg_d  = cap_reg_q;
    cap_ram_d  = cap_ram_q;
    if (wr_act) begin
      cap_addr_d = eff_addr;
      cap_din_d  = host_d_in;
      cap_bhe_d  = bhe_n;
      cap_reg_d  = sel_reg_raw;
      cap_ram_d  = sel_ram_raw & ~sel_reg_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cap_addr_q <= '0;
      cap_din_q  <= '0;
      cap_bhe_q  <= 1'b1;
      cap_reg_q  <= 1'b0;
      cap_ram_q  <= 1'b0;
    end else begin
      cap_addr_q <= cap_addr_d;
      cap_din_q  <= cap_din_d;
      cap_bhe_q  <= cap_bhe_d;
      cap_reg_q  <= cap_reg_d;
      cap_ram_q  <= cap_ram_d;
    end
  end

  // lane steering, one instance per direction
  logic [DW-1:0] wl_word, rl_bus, rl_word, reg_rd_word;
  logic [1:0]    wl_be;
  logic          rl_a0, rl_bhe;
  logic [DW-1:0] unused_wl_rd, unused_rl_wr;
  logic [1:0]    unused_rl_be;

  hbi_lanes #(.BW(BW)) u_wlane (
    .cfg(cfg_q), .a0(cap_addr_q[0]), .bhe_n(cap_bhe_q), .din(cap_din_q), .word_in('0),
    .wr_word(wl_word), .wr_be(wl_be), .rd_bus(unused_wl_rd)
  );

  // pending RAM access
  logic              pend_q, pend_d, pwe_q, pwe_d, pa0_q, pa0_d, pbhe_q, pbhe_d;
  logic [RAM_AW-1:0] paddr_q, paddr_d;
  logic [DW-1:0]     pdata_q, pdata_d, dout_q, dout_d;
  logic [1:0]        pbe_q, pbe_d;
  logic              collide, grant, reg_we;

  assign rl_a0   = pend_q ? pa0_q  : eff_addr[0];
  assign rl_bhe  = pend_q ? pbhe_q : bhe_n;
  assign rl_word = pend_q ? ram_rdata : reg_rd_word;

  hbi_lanes #(.BW(BW)) u_rlane (
    .cfg(cfg_q), .a0(rl_a0), .bhe_n(rl_bhe), .din('0), .word_in(rl_word),
    .wr_word(unused_rl_wr), .wr_be(unused_rl_be), .rd_bus(rl_bus)
  );

  assign collide = eng_act & (eng_addr == paddr_q);
  assign grant   = pend_q & ~collide;
  assign reg_we  = ~pend_q & ~rd_start & wr_end & cap_reg_q;

  always_comb begin
    pend_d  = pend_q;
    pwe_d   = pwe_q;
    pa0_d   = pa0_q;
    pbhe_d  = pbhe_q;
    paddr_d = paddr_q;
    pdata_d = pdata_q;
    pbe_d   = pbe_q;
    dout_d  = dout_q;
    if (grant) begin
      pend_d = 1'b0;
      if (!pwe_q) dout_d = rl_bus;
    end else if (!pend_q) begin
      if (rd_start) begin
        if (sel_reg_raw) begin
          dout_d = rl_bus;
        end else if (sel_ram_raw) begin
          pend_d  = 1'b1;
          pwe_d   = 1'b0;
          paddr_d = eff_addr[RAM_AW:1];
          pa0_d   = eff_addr[0];
          pbhe_d  = bhe_n;
        end
      end else if (wr_end && cap_ram_q) begin
        pend_d  = 1'b1;
        pwe_d   = 1'b1;
        paddr_d = cap_addr_q[RAM_AW:1];
        pdata_d = wl_word;
        pbe_d   = wl_be;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pend_q  <= 1'b0;
      pwe_q   <= 1'b0;
      pa0_q   <= 1'b0;
      pbhe_q  <= 1'b1;
      paddr_q <= '0;
      pdata_q <= '0;
      pbe_q   <= 2'b00;
      dout_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      pwe_q   <= pwe_d;
      pa0_q   <= pa0_d;
      pbhe_q  <= pbhe_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
      pbe_q   <= pbe_d;
      dout_q  <= dout_d;
    end
  end

  // register bank
  hbi_regs #(.DW(DW), .NREG(NREG), .IDXW(REG_IDXW), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(reg_we), .wr_idx(cap_addr_q[REG_IDXW:1]),
    .wr_word(wl_word), .wr_be(wl_be), .rd_idx(eff_addr[REG_IDXW:1]), .rd_word(reg_rd_word)
  );

  // outputs
  assign ram_req    = grant;
  assign ram_we     = pwe_q;
  assign ram_addr   = paddr_q;
  assign ram_wdata  = pdata_q;
  assign ram_be     = pbe_q;
  assign busy_n     = ~(pend_q & collide);
  assign host_d_out = dout_q;
  assign host_d_oe  = rd_act & (sel_reg_raw | sel_ram_raw);

  logic unused_hi;
  assign unused_hi = ^{eff_addr[AW-1:RAM_AW+1], cap_addr_q[AW-1:RAM_AW+1],
                       unused_wl_rd, unused_rl_wr, unused_rl_be};

  // R11: the engine keeps its word; no host request lands on it
  a_r11_no_req_on_engine_word: assert property (@(posedge clk) disable iff (!rst_i)
    ram_req |-> !(eng_act && (eng_addr == ram_addr)));
  a_r11_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_i)
    !busy_n |-> !ram_req);
  a_r11_release_completes: assert property (@(posedge clk) disable iff (!rst_i)
    ram_req |=> busy_n);
  // R12: straps are frozen once the block is live
  a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_i)
    live |=> $stable(cfg_q));
  // R9: an 8-bit write touches exactly one byte
  a_r9_single_lane: assert property (@(posedge clk) disable iff (!rst_i)
    (ram_req && ram_we && !cfg_q.wide) |-> ($countones(ram_be) == 1));
endmodule

// File: tb/hbi_host_if_tb_top.sv
module hbi_host_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_ds, s_pol, s_wide, s_hif, s_mux;
  logic [15:0] host_a, host_d_in, host_d_out;
  logic        host_d_oe, ale_lo, ale_hi, rd_n, wr_n, bhe_n, pcs_n, pcs;
  logic [1:0]  mcs_n;
  logic        busy_n, ram_req, ram_we, eng_act;
  logic [10:0] ram_addr, eng_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic [1:0]  ram_be;

  logic [15:0] mem [0:2047];

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench-side view of the strap configuration
  bit b_ds, b_pol, b_mux;

  always #5 clk = ~clk;

  hbi_host_if dut_i (
    .clk(clk), .rst_n(rst_n),
    .strap_ds_mode(s_ds), .strap_ds_pol(s_pol), .strap_wide(s_wide),
    .strap_hi_first(s_hif), .strap_mux_addr(s_mux),
    .host_a(host_a), .host_d_in(host_d_in), .host_d_out(host_d_out), .host_d_oe(host_d_oe),
    .ale_lo(ale_lo), .ale_hi(ale_hi), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
    .pcs_n(pcs_n), .pcs(pcs), .mcs_n(mcs_n), .busy_n(busy_n),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_be(ram_be), .ram_rdata(ram_rdata), .eng_act(eng_act), .eng_addr(eng_addr)
  );

  // RAM model
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) begin
    if (ram_req && ram_we) begin
      if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
      if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
    end
  end

  // scoreboard queues: 0 = data out, 1 = RAM word, 2 = busy_n, 3 = output enable
  int          src_q[$];
  logic [15:0] exp_q[$];
  logic [10:0] adr_q[$];
  string       tag_q[$];
  event        take_ev;

  initial begin : monitor
    forever begin
      @(take_ev);
      while (src_q.size() > 0) begin
        automatic int          s   = src_q.pop_front();
        automatic logic [15:0] e   = exp_q.pop_front();
        automatic logic [10:0] a   = adr_q.pop_front();
        automatic string       t   = tag_q.pop_front();
        automatic logic [15:0] got;
        case (s)
          0:       got = host_d_out;
          1:       got = mem[a];
          2:       got = {15'd0, busy_n};
          default: got = {15'd0, host_d_oe};
        endcase
        n_vec++;
        if (got !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, got, e);
        end
      end
    end
  end

  task automatic expect_item(input int src, input logic [15:0] e, input logic [10:0] a, input string t);
    src_q.push_back(src);
    exp_q.push_back(e);
    adr_q.push_back(a);
    tag_q.push_back(t);
    -> take_ev;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit on, input bit is_rd);
    if (b_ds) begin
      if (on) wr_n = is_rd;
      rd_n = b_pol ? on : ~on;
    end else begin
      rd_n = ~(on & is_rd);
      wr_n = ~(on & ~is_rd);
    end
  endtask

  task automatic bus_idle();
    strobe(1'b0, 1'b1);
    wr_n = 1'b1;
    pcs_n = 1'b1; pcs = 1'b0; mcs_n = 2'b11; bhe_n = 1'b1;
    host_d_in = 16'h0000;
  endtask

  task automatic apply_reset(input bit ds, input bit pol, input bit wide, input bit hif, input bit mux);
    b_ds = ds; b_pol = pol; b_mux = mux;
    s_ds = ds; s_pol = pol; s_wide = wide; s_hif = hif; s_mux = mux;
    ale_lo = 1'b0; ale_hi = 1'b0; host_a = mux ? 16'hFFFF : 16'h0000;
    bus_idle();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(8);
  endtask

  task automatic put_addr(input logic [15:0] a);
    if (b_mux) begin
      host_a = 16'hFFFF;
      host_d_in = a;
      ale_lo = 1'b1; ale_hi = 1'b1;
      cyc(2);
      ale_lo = 1'b0; ale_hi = 1'b0;
      cyc(1);
    end else begin
      host_a = a;
    end
  endtask

  // sel: 0 register, 1 RAM, 2 register with bad select, 3 RAM with one select high
  task automatic set_sel(input int sel);
    pcs_n = 1'b1; pcs = 1'b0; mcs_n = 2'b11;
    case (sel)
      0: begin pcs_n = 1'b0; pcs = 1'b1; end
      1: mcs_n = 2'b00;
      2: begin pcs_n = 1'b0; pcs = 1'b0; end
      default: mcs_n = 2'b01;
    endcase
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input bit bhe,
                           input int sel, input bit wait_done);
    put_addr(a);
    set_sel(sel);
    bhe_n = bhe;
    host_d_in = ~d;
    strobe(1'b1, 1'b0);
    cyc(2);
    host_d_in = d;
    cyc(3);
    strobe(1'b0, 1'b0);
    cyc(3);
    bus_idle();
    if (wait_done) begin
      while (!busy_n) cyc(1);
      cyc(3);
    end
  endtask

  task automatic bus_read(input logic [15:0] a, input bit bhe, input int sel,
                          input logic [15:0] e, input string t);
    put_addr(a);
    set_sel(sel);
    bhe_n = bhe;
    strobe(1'b1, 1'b1);
    cyc(6);
    while (!busy_n) cyc(1);
    cyc(3);
    expect_item(0, e, 11'd0, t);
    strobe(1'b0, 1'b1);
    cyc(4);
    bus_idle();
    cyc(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    eng_act = 1'b0; eng_addr = 11'd0;

    // 16-bit, separate strobes, non-multiplexed
    apply_reset(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_item(2, 16'h0001, 11'd0, "R1 busy_n after reset");
    expect_item(3, 16'h0000, 11'd0, "R1 oe after reset");
    expect_item(0, 16'h0000, 11'd0, "R1 data after reset");
    s_wide = 1'b0;  // R12: late strap change must be ignored

    bus_read(16'h0000, 1'b0, 0, 16'h0010, "R2 version read");
    bus_write(16'h0000, 16'hFFFF, 1'b0, 0, 1'b1);
    bus_read(16'h0000, 1'b0, 0, 16'h0010, "R2 version unchanged after write");
    bus_write(16'h0002, 16'hFFFF, 1'b0, 0, 1'b1);
    bus_read(16'h0002, 1'b0, 0, 16'h0003, "R3 word1 keeps two bits");
    bus_write(16'h000A, 16'hABCD, 1'b0, 0, 1'b1);
    bus_read(16'h000A, 1'b0, 0, 16'h03CD, "R3 word5 keeps ten bits");
    bus_read(16'h0012, 1'b0, 0, 16'h0000, "R3 word9 reads zero");
    bus_write(16'h0004, 16'h000F, 1'b0, 2, 1'b1);
    bus_read(16'h0004, 1'b0, 0, 16'h0000, "R4 bad select ignored");
    bus_write(16'h0004, 16'h000F, 1'b0, 0, 1'b1);
    bus_read(16'h0004, 1'b0, 0, 16'h000F, "R4 good select written");

    bus_write(16'h0100, 16'h1234, 1'b0, 1, 1'b1);
    expect_item(1, 16'h1234, 11'h080, "R13 R6 RAM write uses final data");
    bus_read(16'h0100, 1'b0, 1, 16'h1234, "R5 R12 RAM wide read");
    bus_write(16'h0100, 16'hFFFF, 1'b0, 3, 1'b1);
    expect_item(1, 16'h1234, 11'h080, "R5 one memory select high");
    bus_write(16'h0100, 16'h5678, 1'b1, 1, 1'b1);
    expect_item(1, 16'h1278, 11'h080, "R8 high lane gated by bhe_n");
    bus_read(16'h0100, 1'b1, 1, 16'h0078, "R8 read high lane zero");

    // R11 write collision
    eng_act = 1'b1; eng_addr = 11'h080;
    bus_write(16'h0100, 16'h9999, 1'b0, 1, 1'b0);
    cyc(2);
    expect_item(2, 16'h0000, 11'd0, "R11 busy during write collision");
    expect_item(1, 16'h1278, 11'h080, "R11 RAM untouched while engine holds word");
    eng_act = 1'b0;
    cyc(4);
    expect_item(2, 16'h0001, 11'd0, "R11 busy released");
    expect_item(1, 16'h9999, 11'h080, "R11 parked write completes");

    // R11 read collision
    eng_act = 1'b1;
    host_a = 16'h0100; set_sel(1); bhe_n = 1'b0;
    strobe(1'b1, 1'b1);
    cyc(6);
    expect_item(2, 16'h0000, 11'd0, "R11 busy during read collision");
    eng_act = 1'b0;
    cyc(4);
    expect_item(0, 16'h9999, 11'd0, "R11 parked read completes");
    strobe(1'b0, 1'b1);
    cyc(4);
    bus_idle();
    cyc(2);

    eng_act = 1'b1; eng_addr = 11'h081;
    bus_write(16'h0100, 16'h4444, 1'b0, 1, 1'b1);
    expect_item(1, 16'h4444, 11'h080, "R11 other engine word no stall");
    eng_act = 1'b0;

    // 8-bit, data strobe active low, low byte first
    apply_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_write(16'h0200, 16'h00AA, 1'b1, 1, 1'b1);
    bus_write(16'h0201, 16'h00BB, 1'b1, 1, 1'b1);
    expect_item(1, 16'hBBAA, 11'h100, "R7 R9 low-first byte writes");
    bus_read(16'h0201, 1'b1, 1, 16'h00BB, "R9 low-first odd byte read");

    // 8-bit, data strobe active high, high byte first
    apply_reset(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    bus_write(16'h0200, 16'h0011, 1'b1, 1, 1'b1);
    expect_item(1, 16'h11AA, 11'h100, "R7 R9 high-first even byte write");
    bus_read(16'h0201, 1'b1, 1, 16'h00AA, "R9 high-first odd byte read");
    bus_read(16'h0200, 1'b1, 1, 16'h0011, "R7 active-high strobe read");

    // 16-bit, multiplexed address
    apply_reset(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    bus_write(16'h0300, 16'hCAFE, 1'b0, 1, 1'b1);
    expect_item(1, 16'hCAFE, 11'h180, "R10 latched address write");
    bus_read(16'h0300, 1'b0, 1, 16'hCAFE, "R10 latched address read");
    bus_read(16'h0000, 1'b0, 0, 16'h0010, "R10 latched register read");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule